// File: doc/BRIEF.md
# Parallel I/O Port Bank

This block gives an 8-bit microcontroller four general-purpose parallel ports. Software reaches them only through byte reads and writes on a simple bus, each port at its own fixed address. The ports differ from one another. Port A has bits whose directions are fixed in hardware, plus one bit whose direction software picks through a control register. Port B only drives outputs. Ports C and D each have a data direction register that sets every bit to input or output.

For every port pin the block drives a separate output value and an output enable, and it takes the pin level in as an input. A read returns the pin level for bits that are inputs and the latched value for bits that are outputs. Writes update the latches on the next rising clock edge. Reads are combinational from the address.

Top module: `parport_bank`

## Requirements
- R1: After reset, all output latches, both direction registers and the control register read 0. Port A output enable is 8'h78, port B output enable is 8'hFF, and ports C and D have their output enables at 0.
- R2: Port A bits 0-2 are always inputs (enable 0) and bits 3-6 are always outputs (enable 1).
- R3: Bit 7 of the control register at 16'h1026 sets the direction of port A bit 7 (1 = output). That register reads back bit 7 only, and its other bits read 0.
- R4: A write to port A (16'h1000) updates the latches of bits 3-7. Bits 0-2 ignore writes and drive 0. A read returns the pins on bits 0-2, the latch on bits 3-6, and on bit 7 the latch if it is an output or the pin if it is an input.
- R5: Port B (16'h1004) is output-only. A write sets its pins on the next cycle, and a read returns the latch.
- R6: Port C is at 16'h1003 with its direction register at 16'h1007. A direction bit of 1 makes the pin an output, so the port C output enable equals the direction register. The direction register reads back.
- R7: A port C read returns the latch for output bits and the pin for input bits.
- R8: Port D is 6 bits wide at 16'h1008, with its direction register at 16'h1009 and the same direction and read rules as port C. Bits 7:6 of both registers read 0 and ignore writes.
- R9: A read of any other address returns 0, and a write to it changes no state. When no write occurs, every latch holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data for busAddr |
| portAIn | input | 8 | Port A pin levels |
| portAOut | output | 8 | Port A output values |
| portAOe | output | 8 | Port A output enables |
| portBOut | output | 8 | Port B output values |
| portBOe | output | 8 | Port B output enables |
| portCIn | input | 8 | Port C pin levels |
| portCOut | output | 8 | Port C output values |
| portCOe | output | 8 | Port C output enables |
| portDIn | input | 6 | Port D pin levels |
| portDOut | output | 6 | Port D output values |
| portDOe | output | 6 | Port D output enables |

## Verification
The hardest case to reach is the port A bit 7 read, because the source of that bit changes when a different register is written. The stimulus first loads a 1 into the bit 7 latch. It then reads the bit with the pin held at the opposite level, once while the bit is an input and once after the control register has made it an output. The mixed-direction reads on ports C and D use direction masks and pin levels that disagree bit by bit, so every bit must come from the right source.

// File: rtl/parport_pkg.sv
package parport_pkg;
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic wrDdrC;
    logic wrD;
    logic wrDdrD;
    logic wrCtl;
  } regStrobes_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_A, SEL_B, SEL_C, SEL_DDRC, SEL_D, SEL_DDRD, SEL_CTL
  } rdSel_t;
endpackage

// File: rtl/parport_ctrl.sv
module parport_ctrl
  import parport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ADR_A = 16'h1000,
  parameter logic [ADDR_W-1:0] ADR_B = 16'h1004,
  parameter logic [ADDR_W-1:0] ADR_C = 16'h1003,
  parameter logic [ADDR_W-1:0] ADR_DDRC = 16'h1007,
  parameter logic [ADDR_W-1:0] ADR_D = 16'h1008,
  parameter logic [ADDR_W-1:0] ADR_DDRD = 16'h1009,
  parameter logic [ADDR_W-1:0] ADR_CTL = 16'h1026
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobes_t       strobes,
  output rdSel_t            rdSel
);
  always_comb begin
    unique case (busAddr)
      ADR_A:    rdSel = SEL_A;
      ADR_B:    rdSel = SEL_B;
      ADR_C:    rdSel = SEL_C;
      ADR_DDRC: rdSel = SEL_DDRC;
      ADR_D:    rdSel = SEL_D;
      ADR_DDRD: rdSel = SEL_DDRD;
      ADR_CTL:  rdSel = SEL_CTL;
      default:  rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes        = '0;
    strobes.wrA    = busWrEn && (rdSel == SEL_A);
    strobes.wrB    = busWrEn && (rdSel == SEL_B);
    strobes.wrC    = busWrEn && (rdSel == SEL_C);
    strobes.wrDdrC = busWrEn && (rdSel == SEL_DDRC);
    strobes.wrD    = busWrEn && (rdSel == SEL_D);
    strobes.wrDdrD = busWrEn && (rdSel == SEL_DDRD);
    strobes.wrCtl  = busWrEn && (rdSel == SEL_CTL);
  end

  // R9: at most one register is written per cycle, and none without busWrEn
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes) && (busWrEn || strobes == '0));
endmodule

// File: rtl/parport_dp.sv
module parport_dp
  import parport_pkg::*;
#(
  parameter int D_W = 6,
  parameter int CTL_DIR_BIT = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  regStrobes_t    strobes,
  input  rdSel_t         rdSel,
  input  logic [7:0]     wData,
  output logic [7:0]     rData,
  input  logic [7:0]     portAIn,
  output logic [7:0]     portAOut,
  output logic [7:0]     portAOe,
  output logic [7:0]     portBOut,
  output logic [7:0]     portBOe,
  input  logic [7:0]     portCIn,
  output logic [7:0]     portCOut,
  output logic [7:0]     portCOe,
  input  logic [D_W-1:0] portDIn,
  output logic [D_W-1:0] portDOut,
  output logic [D_W-1:0] portDOe
);
  localparam int PAD_D = 8 - D_W;
  localparam logic [7:0] A_FIXED_OUT = 8'h78;
  localparam logic [7:0] A_WR_MASK = 8'hF8;

  logic [7:0] latA, latB, latC, ddrC;
  logic [D_W-1:0] latD, ddrD;
  logic a7Dir;
  logic [7:0] rdA, rdC;
  logic [D_W-1:0] rdD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latA <= '0; latB <= '0; latC <= '0; ddrC <= '0;
      latD <= '0; ddrD <= '0; a7Dir <= 1'b0;
    end else begin
      if (strobes.wrA)    latA  <= wData & A_WR_MASK;
      if (strobes.wrB)    latB  <= wData;
      if (strobes.wrC)    latC  <= wData;
      if (strobes.wrDdrC) ddrC  <= wData;
      if (strobes.wrD)    latD  <= wData[D_W-1:0];
      if (strobes.wrDdrD) ddrD  <= wData[D_W-1:0];
      if (strobes.wrCtl)  a7Dir <= wData[CTL_DIR_BIT];
    end
  end

  assign portAOe  = {a7Dir, A_FIXED_OUT[6:0]};
  assign portAOut = latA;
  assign portBOut = latB;
  assign portBOe  = '1;
  assign portCOut = latC;
  assign portCOe  = ddrC;
  assign portDOut = latD;
  assign portDOe  = ddrD;

  // each bit reads its latch when driven and its pin otherwise
  for (genvar i = 0; i < 8; i++) begin : g_rdAC
    assign rdA[i] = portAOe[i] ? latA[i] : portAIn[i];
    assign rdC[i] = ddrC[i] ? latC[i] : portCIn[i];
  end
  for (genvar i = 0; i < D_W; i++) begin : g_rdD
    assign rdD[i] = ddrD[i] ? latD[i] : portDIn[i];
  end

  always_comb begin
    unique case (rdSel)
      SEL_A:    rData = rdA;
      SEL_B:    rData = latB;
      SEL_C:    rData = rdC;
      SEL_DDRC: rData = ddrC;
      SEL_D:    rData = {{PAD_D{1'b0}}, rdD};
      SEL_DDRD: rData = {{PAD_D{1'b0}}, ddrD};
      SEL_CTL:  rData = {a7Dir, 7'b0};
      default:  rData = '0;
    endcase
  end

  p_b_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrB |=> portBOut == $past(wData));
  p_b_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrB |=> $stable(portBOut));
  p_c_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDdrC |=> portCOe == $past(wData));
  p_a7_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCtl |=> portAOe[7] == $past(wData[CTL_DIR_BIT]));
  p_a_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrA |=> portAOut[7:3] == $past(wData[7:3]));
endmodule

// File: rtl/parport_bank.sv
module parport_bank
  import parport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWData,
  output logic [7:0]  busRData,
  input  logic [7:0]  portAIn,
  output logic [7:0]  portAOut,
  output logic [7:0]  portAOe,
  output logic [7:0]  portBOut,
  output logic [7:0]  portBOe,
  input  logic [7:0]  portCIn,
  output logic [7:0]  portCOut,
  output logic [7:0]  portCOe,
  input  logic [5:0]  portDIn,
  output logic [5:0]  portDOut,
  output logic [5:0]  portDOe
);
  regStrobes_t strobes;
  rdSel_t rdSel;

  parport_ctrl #(.ADDR_W(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .strobes(strobes), .rdSel(rdSel)
  );

  parport_dp #(.D_W(6), .CTL_DIR_BIT(7)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .wData(busWData), .rData(busRData),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe),
    .portDIn(portDIn), .portDOut(portDOut), .portDOe(portDOe)
  );

  p_d_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 16'h1008 || busAddr == 16'h1009) |-> busRData[7:6] == 2'b00);
  p_a_inbits_r4: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == 16'h1000 |-> busRData[2:0] == portAIn[2:0]);
endmodule

// File: tb/parport_bank_test.sv
module parport_bank_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busWData = '0;
  logic [7:0] busRData;
  logic [7:0] portAIn = '0, portAOut, portAOe, portBOut, portBOe;
  logic [7:0] portCIn = '0, portCOut, portCOe;
  logic [5:0] portDIn = '0, portDOut, portDOe;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  parport_bank uut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 16'h0000;
  endtask

  task automatic busRead(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRData;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 A oe", portAOe, 8'h78);
    check("R1 B oe", portBOe, 8'hFF);
    check("R1 C oe", portCOe, 8'h00);
    check("R1 D oe", {2'b0, portDOe}, 8'h00);
    check("R1 B out", portBOut, 8'h00);
    portCIn = 8'h5A;
    busRead(16'h1003, d); check("R1 C reads pins", d, 8'h5A);
    busRead(16'h1007, d); check("R1 DDRC", d, 8'h00);
    busRead(16'h1026, d); check("R1 ctl", d, 8'h00);
  endtask

  task automatic t_portA();
    logic [7:0] d;
    busWrite(16'h1000, 8'hFF);
    check("R4 A out masks bits 0-2", portAOut, 8'hF8);
    check("R2 A oe fixed", portAOe, 8'h78);
    portAIn = 8'hA5;
    busRead(16'h1000, d); check("R4 A read pin7=1", d, 8'hFD);
    portAIn = 8'h05;
    busRead(16'h1000, d); check("R4 A read pin7=0", d, 8'h7D);
    busWrite(16'h1026, 8'h80);
    check("R3 A7 output", portAOe, 8'hF8);
    busRead(16'h1000, d); check("R3 A7 reads latch", d, 8'hFD);
    busWrite(16'h1026, 8'h7F);
    check("R3 A7 back to input", portAOe, 8'h78);
    busRead(16'h1026, d); check("R3 ctl readback", d, 8'h00);
    busWrite(16'h1026, 8'hFF);
    busRead(16'h1026, d); check("R3 ctl only bit7", d, 8'h80);
  endtask

  task automatic t_portB();
    logic [7:0] d;
    busWrite(16'h1004, 8'h3C);
    check("R5 B out", portBOut, 8'h3C);
    busRead(16'h1004, d); check("R5 B read", d, 8'h3C);
  endtask

  task automatic t_portC();
    logic [7:0] d;
    busWrite(16'h1007, 8'hF0);
    busWrite(16'h1003, 8'hA5);
    check("R6 C oe", portCOe, 8'hF0);
    check("R6 C out", portCOut, 8'hA5);
    busRead(16'h1007, d); check("R6 DDRC readback", d, 8'hF0);
    portCIn = 8'h3C;
    busRead(16'h1003, d); check("R7 C mixed read", d, 8'hAC);
  endtask

  task automatic t_portD();
    logic [7:0] d;
    busWrite(16'h1009, 8'hFF);
    busRead(16'h1009, d); check("R8 DDRD upper 0", d, 8'h3F);
    check("R8 D oe", {2'b0, portDOe}, 8'h3F);
    busWrite(16'h1008, 8'hFF);
    check("R8 D out", {2'b0, portDOut}, 8'h3F);
    busWrite(16'h1009, 8'h0F);
    portDIn = 6'h30;
    busRead(16'h1008, d); check("R8 D read pins high", d, 8'h3F);
    portDIn = 6'h00;
    busRead(16'h1008, d); check("R8 D read pins low", d, 8'h0F);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    busWrite(16'h1005, 8'hFF);
    busWrite(16'h2004, 8'h00);
    check("R9 B untouched", portBOut, 8'h3C);
    check("R9 C untouched", portCOut, 8'hA5);
    check("R9 C oe untouched", portCOe, 8'hF0);
    busRead(16'h1005, d); check("R9 unmapped read", d, 8'h00);
    busRead(16'h0000, d); check("R9 low read", d, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rstN = 1'b1;
        t_reset();
        t_portA();
        t_portB();
        t_portC();
        t_portD();
        t_unmapped();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule